// File: doc/BRIEF.md
# Ethernet Pause Frame Receiver

This block sits beside a MAC receive path and inspects every incoming frame for a MAC control PAUSE request. It tracks each frame byte by byte through a parsing state machine and compares the destination address with the reserved flow-control multicast group. It then checks the EtherType and opcode and captures the requested pause quanta. At the end of the frame it issues a forwarding verdict. When the request qualifies, it loads a hold-off timer that stalls the local transmitter.

The timer counts in byte times. One quanta is one slot of 64 byte times, so a request for N quanta holds `tx_pause` high for N × 64 pulses of `slot_tick`. A later qualifying request overwrites whatever is left of the count. A request of zero quanta releases the transmitter at once.

The parser has these states: IDLE (no frame open), DEST (destination bytes 0..5), SRC (source bytes 6..11), ETYPE (bytes 12..13), OPCODE (bytes 14..15), QUANTA (bytes 16..17), PAYLOAD (the rest of a well-formed control frame) and REJECT (the rest of a frame that failed a compare). A start-of-frame beat always enters DEST. A mismatch in DEST, ETYPE or OPCODE moves to REJECT. The last byte of each field moves to the next field. An end-of-frame beat always returns to IDLE. The timer has two states. IDLE moves to HOLD on a nonzero load. HOLD moves back to IDLE when the count reaches zero, or on a zero load.

Top module: `eth_pause_rx`

## Requirements
- R1: After reset, `tx_pause` and `verdict_valid` are low and `pause_quanta` is zero.
- R2: A frame is a control frame only if `fc_en` is high and bytes 0..5 equal 01-80-C2-00-00-01. A frame whose destination differs never starts a pause and is always forwarded (`verdict_fwd`=1).
- R3: A pause needs bytes 12..13 equal to 0x88,0x08 and bytes 14..15 equal to 0x00,0x01. Any other value there prevents the pause.
- R4: The quanta is byte 16 (high) and byte 17 (low), big-endian. It appears on `pause_quanta` when the pause is applied. A frame that ends before byte 17 applies no pause.
- R5: A pause is applied only if `rx_byte_cnt` is exactly 64 and `rx_crc_err` is low on the end-of-frame beat.
- R6: With `fc_en` low, nothing is detected. With `full_duplex` low, no pause is applied, but the forwarding verdict is still given.
- R7: `verdict_valid` pulses in the cycle after each end-of-frame beat. `verdict_fwd` is 0 exactly when the frame was a control frame (R2) and `fwd_ctrl` was 0.
- R8: An applied pause raises `tx_pause` two clock edges after the end-of-frame edge. `tx_pause` stays high for exactly quanta × 64 cycles with `slot_tick` high and does not count when `slot_tick` is low.
- R9: A new applied pause replaces the remaining count. An applied quanta of zero drops `tx_pause` at once.
- R10: A start-of-frame beat in the middle of a frame restarts parsing at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_data | input | 8 | Receive byte |
| rx_crc_err | input | 1 | CRC error, sampled with `rx_eof` |
| rx_byte_cnt | input | 16 | Frame byte count, sampled with `rx_eof` |
| fc_en | input | 1 | Pause detection enable |
| full_duplex | input | 1 | Full-duplex mode |
| fwd_ctrl | input | 1 | Forward matched control frames to the application |
| slot_tick | input | 1 | One pulse per byte time |
| tx_pause | output | 1 | Hold off the transmitter |
| verdict_valid | output | 1 | Forwarding verdict strobe |
| verdict_fwd | output | 1 | 1 = forward the frame, 0 = drop it |
| pause_quanta | output | 16 | Quanta of the last applied pause |

## Verification
The embedded assertions check several rules on every cycle. A verdict only ever follows an end-of-frame beat, and a timer load only follows a 64-byte, CRC-clean frame received in full duplex with detection enabled. A drop verdict always traces back to `fwd_ctrl` low. The count never moves without a tick, and each tick takes exactly one byte time off it. The timer state always agrees with the counter. Other behaviour needs stimulus from the bench and cannot be checked by a per-cycle property. This covers the full frame-field decode, including address, type, opcode and the big-endian quanta, and the end-to-end pause length of quanta × 64 ticks. It also covers reload mid-pause, the zero-quanta release and the restart on a mid-frame start.

// File: rtl/eth_pause_pkg.sv
package eth_pause_pkg;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_DEST,
        PS_SRC,
        PS_ETYPE,
        PS_OPCODE,
        PS_QUANTA,
        PS_PAYLOAD,
        PS_REJECT
    } parse_state_t;

    typedef enum logic {
        TS_IDLE,
        TS_HOLD
    } tmr_state_t;

    localparam logic [47:0] FC_GROUP_ADDR = 48'h0180_C200_0001;
    localparam logic [15:0] FC_ETYPE      = 16'h8808;
    localparam logic [15:0] FC_OPCODE     = 16'h0001;

    // Byte p (0..5) of the group address, transmitted first byte first.
    function automatic logic [7:0] group_byte(input logic [2:0] p);
        logic [7:0] b;
        unique case (p)
            3'd0:    b = FC_GROUP_ADDR[47:40];
            3'd1:    b = FC_GROUP_ADDR[39:32];
            3'd2:    b = FC_GROUP_ADDR[31:24];
            3'd3:    b = FC_GROUP_ADDR[23:16];
            3'd4:    b = FC_GROUP_ADDR[15:8];
            default: b = FC_GROUP_ADDR[7:0];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/eth_pause_parser.sv
module eth_pause_parser
    import eth_pause_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int QW        = 16,
    parameter int PAUSE_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [7:0]       rx_data,
    input  logic             rx_crc_err,
    input  logic [CNT_W-1:0] rx_byte_cnt,
    input  logic             fc_en,
    input  logic             full_duplex,
    input  logic             fwd_ctrl,
    output logic             verdict_valid,
    output logic             verdict_fwd,
    output logic             load,
    output logic [QW-1:0]    load_val,
    output logic [QW-1:0]    pause_quanta
);

    localparam int POS_W = 5;
    localparam logic [POS_W-1:0] POS_MAX = '1;

    parse_state_t     state_q, nxt_fld, fld;
    logic [POS_W-1:0] pos_q, pos;
    logic             beat;
    logic             hit_now;
    logic             addr_hit_q, addr_hit;
    logic [7:0]       qhi_q;
    logic [QW-1:0]    frm_quanta_q, frm_quanta;
    logic             is_ctrl, complete, apply;

    // Byte position and field of the current beat
    always_comb begin
        beat = rx_valid && (rx_sof || state_q != PS_IDLE);
        fld  = rx_sof ? PS_DEST : state_q;
        pos  = rx_sof ? '0 : pos_q;
    end

    // Field transition for the current byte
    always_comb begin
        nxt_fld = fld;
        hit_now = 1'b0;
        unique case (fld)
            PS_IDLE:    nxt_fld = PS_IDLE;
            PS_DEST: begin
                if (rx_data != group_byte(pos[2:0]))
                    nxt_fld = PS_REJECT;
                else if (pos == POS_W'(5)) begin
                    nxt_fld = PS_SRC;
                    hit_now = 1'b1;
                end
            end
            PS_SRC:     if (pos == POS_W'(11)) nxt_fld = PS_ETYPE;
            PS_ETYPE: begin
                if (rx_data != ((pos == POS_W'(12)) ? FC_ETYPE[15:8] : FC_ETYPE[7:0]))
                    nxt_fld = PS_REJECT;
                else if (pos == POS_W'(13))
                    nxt_fld = PS_OPCODE;
            end
            PS_OPCODE: begin
                if (rx_data != ((pos == POS_W'(14)) ? FC_OPCODE[15:8] : FC_OPCODE[7:0]))
                    nxt_fld = PS_REJECT;
                else if (pos == POS_W'(15))
                    nxt_fld = PS_QUANTA;
            end
            PS_QUANTA:  if (pos == POS_W'(17)) nxt_fld = PS_PAYLOAD;
            PS_PAYLOAD: nxt_fld = PS_PAYLOAD;
            PS_REJECT:  nxt_fld = PS_REJECT;
            default:    nxt_fld = PS_REJECT;
        endcase
    end

    // End-of-frame decision
    always_comb begin
        addr_hit   = hit_now || (!rx_sof && addr_hit_q);
        frm_quanta = (fld == PS_QUANTA && pos == POS_W'(17))
                   ? QW'({qhi_q, rx_data}) : frm_quanta_q;
        is_ctrl    = fc_en && addr_hit;
        complete   = (nxt_fld == PS_PAYLOAD);
        apply      = is_ctrl && complete && full_duplex && !rx_crc_err
                   && (rx_byte_cnt == CNT_W'(PAUSE_LEN));
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            pos_q   <= '0;
        end else if (beat) begin
            state_q <= rx_eof ? PS_IDLE : nxt_fld;
            pos_q   <= rx_eof ? '0 : ((pos == POS_MAX) ? POS_MAX : pos + 1'b1);
        end
    end

    // Captured fields and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_hit_q    <= 1'b0;
            qhi_q         <= '0;
            frm_quanta_q  <= '0;
            verdict_valid <= 1'b0;
            verdict_fwd   <= 1'b0;
            load          <= 1'b0;
            load_val      <= '0;
            pause_quanta  <= '0;
        end else begin
            verdict_valid <= 1'b0;
            load          <= 1'b0;
            if (beat) begin
                addr_hit_q   <= addr_hit;
                frm_quanta_q <= frm_quanta;
                if (fld == PS_QUANTA && pos == POS_W'(16))
                    qhi_q <= rx_data;
                if (rx_eof) begin
                    verdict_valid <= 1'b1;
                    verdict_fwd   <= !is_ctrl || fwd_ctrl;
                    if (apply) begin
                        load         <= 1'b1;
                        load_val     <= frm_quanta;
                        pause_quanta <= frm_quanta;
                    end
                end
            end
        end
    end

    p_verdict_after_eof_r7: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> $past(rx_valid && rx_eof));

    p_drop_by_setting_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && !verdict_fwd) |-> $past(!fwd_ctrl && fc_en));

    p_load_len_crc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> $past(rx_eof && !rx_crc_err && rx_byte_cnt == CNT_W'(PAUSE_LEN)));

    p_load_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> $past(full_duplex && fc_en));

    p_load_has_verdict_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> verdict_valid);

endmodule

// File: rtl/eth_pause_timer.sv
module eth_pause_timer
    import eth_pause_pkg::*;
#(
    parameter int QW         = 16,
    parameter int SLOT_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [QW-1:0] load_val,
    input  logic          slot_tick,
    output logic          tx_pause
);

    localparam int SLOT_SH = $clog2(SLOT_BYTES);
    localparam int RW      = QW + SLOT_SH;

    tmr_state_t    state_q, state_d;
    logic [RW-1:0] remaining_q;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_IDLE: if (load && load_val != '0) state_d = TS_HOLD;
            TS_HOLD: begin
                if (load)
                    state_d = (load_val != '0) ? TS_HOLD : TS_IDLE;
                else if (slot_tick && remaining_q == RW'(1))
                    state_d = TS_IDLE;
            end
            default: state_d = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TS_IDLE;
        else        state_q <= state_d;
    end

    // Byte-time counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            remaining_q <= '0;
        else if (load)
            remaining_q <= RW'(load_val) * RW'(SLOT_BYTES);
        else if (slot_tick && remaining_q != '0)
            remaining_q <= remaining_q - 1'b1;
    end

    // Output
    always_comb tx_pause = (state_q == TS_HOLD);

    p_state_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pause == (remaining_q != '0));

    p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && slot_tick && remaining_q != '0) |=> remaining_q == $past(remaining_q) - 1'b1);

    p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !slot_tick) |=> $stable(remaining_q));

    p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> tx_pause == ($past(load_val) != '0));

endmodule

// File: rtl/eth_pause_rx.sv
module eth_pause_rx
    import eth_pause_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int QW         = 16,
    parameter int PAUSE_LEN  = 64,
    parameter int SLOT_BYTES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [7:0]       rx_data,
    input  logic             rx_crc_err,
    input  logic [CNT_W-1:0] rx_byte_cnt,
    input  logic             fc_en,
    input  logic             full_duplex,
    input  logic             fwd_ctrl,
    input  logic             slot_tick,
    output logic             tx_pause,
    output logic             verdict_valid,
    output logic             verdict_fwd,
    output logic [QW-1:0]    pause_quanta
);

    logic          load;
    logic [QW-1:0] load_val;

    eth_pause_parser #(
        .CNT_W     (CNT_W),
        .QW        (QW),
        .PAUSE_LEN (PAUSE_LEN)
    ) u_parser (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_valid      (rx_valid),
        .rx_sof        (rx_sof),
        .rx_eof        (rx_eof),
        .rx_data       (rx_data),
        .rx_crc_err    (rx_crc_err),
        .rx_byte_cnt   (rx_byte_cnt),
        .fc_en         (fc_en),
        .full_duplex   (full_duplex),
        .fwd_ctrl      (fwd_ctrl),
        .verdict_valid (verdict_valid),
        .verdict_fwd   (verdict_fwd),
        .load          (load),
        .load_val      (load_val),
        .pause_quanta  (pause_quanta)
    );

    eth_pause_timer #(
        .QW         (QW),
        .SLOT_BYTES (SLOT_BYTES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_val  (load_val),
        .slot_tick (slot_tick),
        .tx_pause  (tx_pause)
    );

endmodule

// File: tb/eth_pause_rx_bench.sv
module eth_pause_rx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SLOT       = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_crc_err = 1'b0;
    logic [15:0] rx_byte_cnt = '0;
    logic        fc_en = 1'b0, full_duplex = 1'b0, fwd_ctrl = 1'b0;
    logic        slot_tick = 1'b0;
    logic        tx_pause, verdict_valid, verdict_fwd;
    logic [15:0] pause_quanta;

    int checks = 0;
    int errors = 0;
    logic [7:0]  fr [0:63];
    logic [15:0] exp_q = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_pause_rx u_eth_pause_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .rx_crc_err(rx_crc_err),
        .rx_byte_cnt(rx_byte_cnt), .fc_en(fc_en), .full_duplex(full_duplex),
        .fwd_ctrl(fwd_ctrl), .slot_tick(slot_tick), .tx_pause(tx_pause),
        .verdict_valid(verdict_valid), .verdict_fwd(verdict_fwd),
        .pause_quanta(pause_quanta)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected decisions, from the requirements
    function automatic bit exp_ctrl(input bit en, input bit da_ok);
        return en && da_ok;
    endfunction

    function automatic bit exp_apply(input bit en, input bit da_ok, input bit ty_ok,
                                     input bit op_ok, input int len, input int cnt,
                                     input bit crc, input bit fd);
        return exp_ctrl(en, da_ok) && ty_ok && op_ok && len >= 18 && cnt == 64 && !crc && fd;
    endfunction

    task automatic build(input logic [15:0] q, input bit da_ok, input bit ty_ok, input bit op_ok);
        logic [47:0] da = 48'h0180_C200_0001;
        for (int i = 0; i < 64; i++) fr[i] = 8'($urandom_range(0, 255));
        for (int i = 0; i < 6; i++) fr[i] = da[47-8*i -: 8];
        if (!da_ok) fr[$urandom_range(0, 5)] ^= 8'h10;
        fr[12] = 8'h88; fr[13] = 8'h08;
        if (!ty_ok) fr[12 + $urandom_range(0, 1)] ^= 8'h01;
        fr[14] = 8'h00; fr[15] = 8'h01;
        if (!op_ok) fr[14 + $urandom_range(0, 1)] ^= 8'h02;
        fr[16] = q[15:8]; fr[17] = q[7:0];
    endtask

    // Sends fr[0..len-1]; returns verdict sampled the cycle after eof.
    task automatic send(input int len, input int cnt, input bit crc,
                        output bit vv, output bit vf);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1);
            rx_data = fr[i]; rx_byte_cnt = 16'(cnt); rx_crc_err = crc;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_crc_err = 1'b0;
        vv = verdict_valid; vf = verdict_fwd;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            slot_tick = 1'b1;
        end
        @(negedge clk);
        slot_tick = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit vv, vf;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tx_pause == 0 && verdict_valid == 0, "R1", int'(tx_pause), 0);
        check(pause_quanta == 0, "R1", int'(pause_quanta), 0);
        rst_n = 1'b1;
        fc_en = 1'b1; full_duplex = 1'b1; fwd_ctrl = 1'b0;

        // Random mix
        for (int it = 0; it < 48; it++) begin
            int kind = $urandom_range(0, 7);
            logic [15:0] q = 16'($urandom_range(1, 3));
            bit da_ok = (kind != 1), ty_ok = (kind != 2), op_ok = (kind != 3);
            int cnt = (kind == 4) ? (($urandom_range(0, 1) != 0) ? 65 : 63) : 64;
            bit crc = (kind == 5);
            bit ap, ctl;
            fc_en = (kind != 6); full_duplex = (kind != 7);
            fwd_ctrl = 1'($urandom_range(0, 1));
            build(q, da_ok, ty_ok, op_ok);
            ap  = exp_apply(fc_en, da_ok, ty_ok, op_ok, 64, cnt, crc, full_duplex);
            ctl = exp_ctrl(fc_en, da_ok);
            send(64, cnt, crc, vv, vf);
            check(vv == 1, "R7", int'(vv), 1);
            // R2/R6/R7: forward unless control frame and fwd_ctrl low
            check(vf == (!ctl || fwd_ctrl), "R7", int'(vf), int'(!ctl || fwd_ctrl));
            if (ap) begin
                exp_q = q;
                check(tx_pause == 1, "R8", int'(tx_pause), 1);
                check(pause_quanta == exp_q, "R4", int'(pause_quanta), int'(exp_q));
                ticks(int'(q) * SLOT - 1);
                check(tx_pause == 1, "R8", int'(tx_pause), 1);
                ticks(1);
                check(tx_pause == 0, "R8", int'(tx_pause), 0);
            end else begin
                // R2, R3, R5, R6: no pause, quanta unchanged
                check(tx_pause == 0, "R5", int'(tx_pause), 0);
                check(pause_quanta == exp_q, "R3", int'(pause_quanta), int'(exp_q));
            end
        end
        fc_en = 1'b1; full_duplex = 1'b1; fwd_ctrl = 1'b0;

        // R8: no counting without ticks
        build(16'd1, 1, 1, 1);
        send(64, 64, 0, vv, vf);
        repeat (100) @(negedge clk);
        ticks(SLOT - 1);
        check(tx_pause == 1, "R8", int'(tx_pause), 1);
        ticks(1);
        check(tx_pause == 0, "R8", int'(tx_pause), 0);

        // R9: reload replaces remaining count
        build(16'd3, 1, 1, 1);
        send(64, 64, 0, vv, vf);
        ticks(100);
        build(16'd1, 1, 1, 1);
        send(64, 64, 0, vv, vf);
        ticks(SLOT - 1);
        check(tx_pause == 1, "R9", int'(tx_pause), 1);
        ticks(1);
        check(tx_pause == 0, "R9", int'(tx_pause), 0);

        // R9: zero quanta releases at once
        build(16'd4, 1, 1, 1);
        send(64, 64, 0, vv, vf);
        ticks(5);
        build(16'd0, 1, 1, 1);
        send(64, 64, 0, vv, vf);
        check(tx_pause == 0, "R9", int'(tx_pause), 0);
        check(pause_quanta == 0, "R9", int'(pause_quanta), 0);

        // R4: byte order of quanta
        build(16'h0102, 1, 1, 1);
        send(64, 64, 0, vv, vf);
        check(pause_quanta == 16'h0102, "R4", int'(pause_quanta), 258);
        build(16'd0, 1, 1, 1);
        send(64, 64, 0, vv, vf);

        // R4: frame ending before byte 17 applies nothing
        build(16'd2, 1, 1, 1);
        send(17, 64, 0, vv, vf);
        check(tx_pause == 0, "R4", int'(tx_pause), 0);
        check(vv == 1 && vf == 0, "R7", int'(vf), 0);

        // R10: restart on start-of-frame inside a frame
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = 1'b0; rx_data = 8'hA5;
        end
        build(16'd1, 1, 1, 1);
        send(64, 64, 0, vv, vf);
        check(tx_pause == 1, "R10", int'(tx_pause), 1);
        check(pause_quanta == 1, "R10", int'(pause_quanta), 1);
        ticks(SLOT);
        check(tx_pause == 0, "R10", int'(tx_pause), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule